// File: doc/BRIEF.md
# EEPROM Word Address Pointer and Page Write Buffer

This block holds the internal word pointer of a small serial EEPROM together with the buffer that gathers one page of write data. A protocol engine drives it with single-cycle strobes: load a new word address, push a received data byte, step the pointer after a byte has been read out, commit the gathered page, or drop it. The block presents the current pointer and the array byte stored there. It also runs a self-timed programming cycle that copies the buffered bytes into the array.

The pointer advances in two different ways. A pushed data byte moves only the offset bits inside the current page. The page part never changes, so a long burst wraps to the start of the page and overwrites bytes buffered earlier. A read step moves the whole pointer and wraps from the top of the array to address zero. A commit starts a busy period of a parameterised length. During this period one array write strobe fires for each buffered byte, and every strobe from the engine is ignored.

The parameter `ADDR_W` selects the variant. A value of 8 gives 256 bytes in 8-byte pages. A value from 9 to 11 gives 16-byte pages over 512 to 2048 bytes. The array itself is modelled inside the block with a combinational read port.

Top module: `eep_wordptr_pagebuf`

## Requirements
- R1: After reset, `rd_addr` is 0, `busy` is 0, `arr_we` is 0 and the page buffer holds no bytes.
- R2: An accepted load makes `rd_addr` equal to `ld_addr` on the next cycle and discards every buffered byte, so a following commit does not start a write cycle.
- R3: An accepted byte push stores `wr_data` in the buffer at the pointer's page offset, which is the low 3 bits when `ADDR_W` is 8. It then increments only those offset bits, wrapping from the last offset of the page to offset 0. A later push to the same offset replaces the earlier byte.
- R4: An accepted read step increments `rd_addr` by one modulo 2^ADDR_W. `rd_data` always shows the array byte at `rd_addr` in the same cycle.
- R5: A commit while at least one byte is buffered raises `busy` on the next cycle and holds it for exactly max(WRITE_CYCLES, page size) cycles. In the first page-size cycles of that period, `arr_we` pulses once per buffered offset, in ascending offset order. Each pulse carries the page latched at the first push and the last byte pushed to that offset.
- R6: A commit while the buffer is empty has no effect. The buffer is empty again after the write cycle ends.
- R7: An abort empties the buffer and causes no array write. The pointer keeps its value.
- R8: While `busy` is 1, every load, push, read step, commit and abort is ignored. `rd_addr` stays fixed and the bytes being written are not changed.
- R9: When several strobes are high in one idle cycle, only one acts. The order is abort, then commit with a non-empty buffer, then load, then push, then read step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load the word pointer |
| ld_addr | input | ADDR_W | Address for a load |
| wr_en | input | 1 | Push one data byte into the page buffer |
| wr_data | input | 8 | Data byte for a push |
| rd_adv | input | 1 | Step the pointer after a byte was read |
| commit | input | 1 | Start the timed write of the buffered page |
| abort | input | 1 | Drop the buffered page |
| rd_addr | output | ADDR_W | Current word pointer |
| rd_data | output | 8 | Array byte at the pointer |
| busy | output | 1 | Timed write cycle in progress |
| arr_we | output | 1 | Array write strobe |
| arr_waddr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The bench provokes the collision of a commit and a byte push by raising both strobes in the same idle cycle after one byte has been buffered. It judges the result at the ports. The write cycle must produce exactly one array strobe, for the earlier byte. The pointer must not have advanced past that byte, which shows the push was dropped rather than merged into the committed page. Other collisions, such as load with push or abort with load, are judged the same way through the pointer value on the following cycle.

// File: rtl/eep_ptr_pkg.sv
package eep_ptr_pkg;

    typedef enum logic [2:0] {
        OP_IDLE,
        OP_ABORT,
        OP_COMMIT,
        OP_LOAD,
        OP_WRITE,
        OP_READ
    } op_e;

    typedef struct packed {
        logic ld;
        logic wr;
        logic rd;
        logic commit;
        logic abort;
    } strobe_t;

    // Offset width inside one page: small array uses 8-byte pages.
    function automatic int page_ofs_bits(int addr_w);
        return (addr_w <= 8) ? 3 : 4;
    endfunction

    // One operation per idle cycle, fixed priority.
    function automatic op_e pick_op(strobe_t s, logic busy, logic buf_empty);
        if (busy)                      return OP_IDLE;
        if (s.abort)                   return OP_ABORT;
        if (s.commit && !buf_empty)    return OP_COMMIT;
        if (s.ld)                      return OP_LOAD;
        if (s.wr)                      return OP_WRITE;
        if (s.rd)                      return OP_READ;
        return OP_IDLE;
    endfunction

endpackage

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr
    import eep_ptr_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int OFS_W  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [ADDR_W-1:0] ld_addr,
    output logic [ADDR_W-1:0] ptr
);

    logic [ADDR_W-1:0] ptr_q;
    logic [ADDR_W-1:0] ptr_page_step;
    logic [ADDR_W-1:0] ptr_array_step;

    // Write direction: offset bits wrap inside the page.
    always_comb begin
        ptr_page_step = {ptr_q[ADDR_W-1:OFS_W], ptr_q[OFS_W-1:0] + 1'b1};
    end

    // Read direction: whole pointer wraps over the array.
    always_comb begin
        ptr_array_step = ptr_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else begin
            case (op)
                OP_LOAD:  ptr_q <= ld_addr;
                OP_WRITE: ptr_q <= ptr_page_step;
                OP_READ:  ptr_q <= ptr_array_step;
                default:  ptr_q <= ptr_q;
            endcase
        end
    end

    assign ptr = ptr_q;

endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf
    import eep_ptr_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int OFS_W      = 3,
    parameter int PAGE_BYTES = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  op_e                     op,
    input  logic [ADDR_W-1:0]       ptr,
    input  logic [7:0]              wr_data,
    input  logic                    cycle_done,
    input  logic [OFS_W-1:0]        sel_ofs,
    output logic                    empty,
    output logic [ADDR_W-OFS_W-1:0] page_tag,
    output logic [7:0]              sel_data,
    output logic                    sel_vld
);

    logic [7:0]              lane_data [PAGE_BYTES];
    logic [PAGE_BYTES-1:0]   lane_vld;
    logic [ADDR_W-OFS_W-1:0] tag_q;
    logic                    clear;

    assign clear = (op == OP_ABORT) || (op == OP_LOAD) || cycle_done;

    for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_lane
        logic [7:0] byte_q;
        logic       vld_q;
        logic       hit;

        assign hit = (op == OP_WRITE) && (ptr[OFS_W-1:0] == OFS_W'(i));

        always_ff @(posedge clk) begin
            if (rst) begin
                byte_q <= '0;
                vld_q  <= 1'b0;
            end else if (clear) begin
                vld_q  <= 1'b0;
            end else if (hit) begin
                byte_q <= wr_data;
                vld_q  <= 1'b1;
            end
        end

        assign lane_data[i] = byte_q;
        assign lane_vld[i]  = vld_q;
    end

    // Page of the pending write is fixed by the first buffered byte.
    always_ff @(posedge clk) begin
        if (rst) begin
            tag_q <= '0;
        end else if ((op == OP_WRITE) && (lane_vld == '0)) begin
            tag_q <= ptr[ADDR_W-1:OFS_W];
        end
    end

    assign empty    = (lane_vld == '0);
    assign page_tag = tag_q;
    assign sel_data = lane_data[sel_ofs];
    assign sel_vld  = lane_vld[sel_ofs];

endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer
    import eep_ptr_pkg::*;
#(
    parameter int BUSY_CYCLES = 24,
    parameter int PAGE_BYTES  = 8,
    parameter int OFS_W       = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  op_e              op,
    output logic             busy,
    output logic             cycle_done,
    output logic             scan_act,
    output logic [OFS_W-1:0] scan_ofs
);

    localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic             last;

    assign last = busy_q && (cnt_q == CNT_W'(BUSY_CYCLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (op == OP_COMMIT) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
        end else if (last) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q) begin
            cnt_q  <= cnt_q + 1'b1;
        end
    end

    assign busy       = busy_q;
    assign cycle_done = last;
    assign scan_act   = busy_q && (cnt_q < CNT_W'(PAGE_BYTES));
    assign scan_ofs   = cnt_q[OFS_W-1:0];

endmodule

// File: rtl/eep_array.sv
module eep_array #(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [7:0]        wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [7:0]        rdata
);

    localparam int DEPTH = 1 << ADDR_W;

    logic [7:0] cells [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            cells[waddr] <= wdata;
        end
    end

    assign rdata = cells[raddr];

endmodule

// File: rtl/eep_wordptr_pagebuf.sv
module eep_wordptr_pagebuf
    import eep_ptr_pkg::*;
#(
    parameter int ADDR_W       = 8,
    parameter int WRITE_CYCLES = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              rd_adv,
    input  logic              commit,
    input  logic              abort,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_waddr,
    output logic [7:0]        arr_wdata
);

    localparam int OFS_W       = page_ofs_bits(ADDR_W);
    localparam int PAGE_BYTES  = 1 << OFS_W;
    localparam int BUSY_CYCLES = (WRITE_CYCLES > PAGE_BYTES) ? WRITE_CYCLES : PAGE_BYTES;

    strobe_t                 strobes;
    op_e                     op;
    logic [ADDR_W-1:0]       ptr;
    logic                    buf_empty;
    logic [ADDR_W-OFS_W-1:0] page_tag;
    logic [7:0]              sel_data;
    logic                    sel_vld;
    logic                    busy_i;
    logic                    cycle_done;
    logic                    scan_act;
    logic [OFS_W-1:0]        scan_ofs;

    assign strobes = '{ld: ld_en, wr: wr_en, rd: rd_adv, commit: commit, abort: abort};

    always_comb begin
        op = pick_op(strobes, busy_i, buf_empty);
    end

    eep_addr_ptr #(
        .ADDR_W (ADDR_W),
        .OFS_W  (OFS_W)
    ) u_ptr (
        .clk     (clk),
        .rst     (rst),
        .op      (op),
        .ld_addr (ld_addr),
        .ptr     (ptr)
    );

    eep_page_buf #(
        .ADDR_W     (ADDR_W),
        .OFS_W      (OFS_W),
        .PAGE_BYTES (PAGE_BYTES)
    ) u_buf (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .ptr        (ptr),
        .wr_data    (wr_data),
        .cycle_done (cycle_done),
        .sel_ofs    (scan_ofs),
        .empty      (buf_empty),
        .page_tag   (page_tag),
        .sel_data   (sel_data),
        .sel_vld    (sel_vld)
    );

    eep_wr_timer #(
        .BUSY_CYCLES (BUSY_CYCLES),
        .PAGE_BYTES  (PAGE_BYTES),
        .OFS_W       (OFS_W)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .op         (op),
        .busy       (busy_i),
        .cycle_done (cycle_done),
        .scan_act   (scan_act),
        .scan_ofs   (scan_ofs)
    );

    assign arr_we    = scan_act && sel_vld;
    assign arr_waddr = {page_tag, scan_ofs};
    assign arr_wdata = sel_data;

    eep_array #(
        .ADDR_W (ADDR_W)
    ) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (ptr),
        .rdata (rd_data)
    );

    assign rd_addr = ptr;
    assign busy    = busy_i;

endmodule

// File: rtl/eep_wordptr_pagebuf_chk.sv
module eep_wordptr_pagebuf_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ld_en,
    input logic [ADDR_W-1:0] ld_addr,
    input logic              wr_en,
    input logic              rd_adv,
    input logic              commit,
    input logic              abort,
    input logic [ADDR_W-1:0] rd_addr,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_waddr
);

    localparam int OFS_W = eep_ptr_pkg::page_ofs_bits(ADDR_W);

    AST_PTR_FROZEN_BUSY: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(rd_addr)); // R8

    AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        arr_we |-> busy); // R5

    AST_WE_ONE_PAGE: assert property (@(posedge clk) disable iff (rst)
        (arr_we && $past(arr_we)) |->
            (arr_waddr[ADDR_W-1:OFS_W] == $past(arr_waddr[ADDR_W-1:OFS_W]))); // R5

    AST_BUSY_FROM_COMMIT: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(commit)); // R5

    AST_PUSH_STAYS_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        (!busy && wr_en && !abort && !commit && !ld_en) |=>
            (rd_addr[ADDR_W-1:OFS_W] == $past(rd_addr[ADDR_W-1:OFS_W]))); // R3

    AST_READ_STEP: assert property (@(posedge clk) disable iff (rst)
        (!busy && rd_adv && !wr_en && !ld_en && !abort && !commit) |=>
            (rd_addr == ADDR_W'($past(rd_addr) + 1'b1))); // R4

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (!busy && ld_en && !abort && !commit) |=> (rd_addr == $past(ld_addr))); // R2

    AST_ABORT_NO_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (!busy && abort) |=> (!busy && $stable(rd_addr))); // R7

endmodule

bind eep_wordptr_pagebuf eep_wordptr_pagebuf_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .ld_en     (ld_en),
    .ld_addr   (ld_addr),
    .wr_en     (wr_en),
    .rd_adv    (rd_adv),
    .commit    (commit),
    .abort     (abort),
    .rd_addr   (rd_addr),
    .busy      (busy),
    .arr_we    (arr_we),
    .arr_waddr (arr_waddr)
);

// File: tb/eep_wordptr_pagebuf_tb.sv
module eep_wordptr_pagebuf_tb;

    localparam int ADDR_W = 8;
    localparam int WCYC   = 24;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              ld_en = 1'b0;
    logic [ADDR_W-1:0] ld_addr = '0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_data = '0;
    logic              rd_adv = 1'b0;
    logic              commit = 1'b0;
    logic              abort = 1'b0;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]        rd_data;
    logic              busy;
    logic              arr_we;
    logic [ADDR_W-1:0] arr_waddr;
    logic [7:0]        arr_wdata;

    int checks = 0;
    int failures = 0;
    int we_cnt = 0;
    logic [7:0] we_addr [16];
    logic [7:0] we_data [16];

    always #10 clk = ~clk;

    eep_wordptr_pagebuf #(
        .ADDR_W       (ADDR_W),
        .WRITE_CYCLES (WCYC)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .ld_en     (ld_en),
        .ld_addr   (ld_addr),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_adv    (rd_adv),
        .commit    (commit),
        .abort     (abort),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .busy      (busy),
        .arr_we    (arr_we),
        .arr_waddr (arr_waddr),
        .arr_wdata (arr_wdata)
    );

    // Log array write strobes, sampled away from the active edge.
    always @(negedge clk) begin
        if (arr_we && we_cnt < 16) begin
            we_addr[we_cnt] = arr_waddr;
            we_data[we_cnt] = arr_wdata;
            we_cnt = we_cnt + 1;
        end else if (arr_we) begin
            we_cnt = we_cnt + 1;
        end
    end

    typedef struct packed {
        logic       ld;
        logic       wr;
        logic       rd;
        logic       ab;
        logic       cm;
        logic [7:0] addr;
        logic [7:0] data;
        logic [7:0] exp_ptr;
        logic       exp_busy;
        int         req;
    } step_t;

    localparam int NSTEP = 15;
    localparam step_t STEPS [NSTEP] = '{
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h15, 8'h00, 8'h15, 1'b0, 2}, // R2 load
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA0, 8'h16, 1'b0, 3}, // R3 push
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA1, 8'h17, 1'b0, 3}, // R3 push
        '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hA2, 8'h10, 1'b0, 3}, // R3 page wrap
        '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00, 8'h10, 1'b0, 7}, // R7 abort keeps ptr
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'h10, 1'b0, 7}, // R7 buffer emptied
        '{1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'hFE, 8'h00, 8'hFE, 1'b0, 2}, // R2 load
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'hFF, 1'b0, 4}, // R4 step
        '{1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00, 8'h00, 1'b0, 4}, // R4 array wrap
        '{1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'h44, 8'h33, 8'h44, 1'b0, 9}, // R9 load wins
        '{1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'h00, 8'h11, 8'h45, 1'b0, 9}, // R9 push over read
        '{1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h3C, 8'h00, 8'h45, 1'b0, 9}, // R9 abort over load
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'h45, 1'b0, 6}, // R6 empty commit
        '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h3C, 8'h05, 8'h3C, 1'b0, 2}, // R2 load over push
        '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00, 8'h3C, 1'b0, 2}  // R2 load emptied buffer
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Drive strobes at a negedge, return at the next negedge with them cleared.
    task automatic do_op(input logic l, input logic w, input logic r, input logic a,
                         input logic c, input logic [7:0] ad, input logic [7:0] d);
        ld_en = l; wr_en = w; rd_adv = r; abort = a; commit = c;
        ld_addr = ad; wr_data = d;
        @(negedge clk);
        ld_en = 1'b0; wr_en = 1'b0; rd_adv = 1'b0; abort = 1'b0; commit = 1'b0;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        int n;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        check(rd_addr == 8'h00, "R1", "rd_addr after reset", rd_addr, 0);
        check(busy == 1'b0, "R1", "busy after reset", busy, 0);
        check(arr_we == 1'b0, "R1", "arr_we after reset", arr_we, 0);
        do_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
        check(busy == 1'b0, "R1", "commit after reset (empty buffer)", busy, 0);

        for (int i = 0; i < NSTEP; i++) begin
            do_op(STEPS[i].ld, STEPS[i].wr, STEPS[i].rd, STEPS[i].ab, STEPS[i].cm,
                  STEPS[i].addr, STEPS[i].data);
            check(rd_addr == STEPS[i].exp_ptr, $sformatf("R%0d", STEPS[i].req),
                  $sformatf("step %0d rd_addr", i), rd_addr, STEPS[i].exp_ptr);
            check(busy == STEPS[i].exp_busy, $sformatf("R%0d", STEPS[i].req),
                  $sformatf("step %0d busy", i), busy, STEPS[i].exp_busy);
        end

        // R3 R5: ten pushes into an 8-byte page, then commit
        do_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h20, 8'h00);
        for (int i = 0; i < 10; i++) begin
            do_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'(8'hC0 + i));
        end
        check(rd_addr == 8'h22, "R3", "pointer after 10 pushes", rd_addr, 8'h22);
        we_cnt = 0;
        do_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
        check(busy == 1'b1, "R5", "busy after commit", busy, 1);
        wait_idle(n);
        check(n == WCYC, "R5", "busy length", n, WCYC);
        check(we_cnt == 8, "R5", "array strobes for full page", we_cnt, 8);
        for (int i = 0; i < 8; i++) begin
            logic [7:0] ed;
            ed = (i < 2) ? 8'(8'hC8 + i) : 8'(8'hC0 + i);
            check(we_addr[i] == 8'(8'h20 + i), "R5", $sformatf("write %0d address", i),
                  we_addr[i], 8'h20 + i);
            check(we_data[i] == ed, "R3", $sformatf("write %0d data", i), we_data[i], ed);
        end
        check(rd_addr == 8'h22, "R5", "pointer after write cycle", rd_addr, 8'h22);
        do_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
        check(busy == 1'b0, "R6", "buffer empty after write cycle", busy, 0);

        // R4 read back across the page
        do_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h20, 8'h00);
        check(rd_data == 8'hC8, "R4", "rd_data at 0x20", rd_data, 8'hC8);
        for (int i = 1; i < 8; i++) begin
            logic [7:0] ed;
            ed = (i < 2) ? 8'(8'hC8 + i) : 8'(8'hC0 + i);
            do_op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
            check(rd_data == ed, "R4", $sformatf("rd_data at 0x%0h", 8'h20 + i), rd_data, ed);
        end

        // R8 strobes ignored during the write cycle
        do_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h53, 8'h00);
        do_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h5A);
        do_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h5B);
        we_cnt = 0;
        do_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
        do_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h99, 8'h00);
        check(rd_addr == 8'h55, "R8", "load during busy", rd_addr, 8'h55);
        do_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'hEE);
        check(rd_addr == 8'h55, "R8", "push during busy", rd_addr, 8'h55);
        do_op(1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h00, 8'h00);
        do_op(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h00);
        check(rd_addr == 8'h55, "R8", "read step during busy", rd_addr, 8'h55);
        wait_idle(n);
        check(we_cnt == 2, "R8", "strobes with ignored push/abort", we_cnt, 2);
        check(we_addr[0] == 8'h53 && we_data[0] == 8'h5A, "R8", "first write", we_data[0], 8'h5A);
        check(we_addr[1] == 8'h54 && we_data[1] == 8'h5B, "R8", "second write", we_data[1], 8'h5B);
        do_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h55, 8'h00);
        do_op(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 8'h00, 8'h00);
        check(busy == 1'b0, "R8", "push during busy not buffered", busy, 0);

        // R9 commit and push in the same cycle: commit wins, push dropped
        do_op(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'h60, 8'h00);
        do_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 8'h11);
        we_cnt = 0;
        do_op(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 8'h22);
        check(busy == 1'b1, "R9", "commit taken", busy, 1);
        check(rd_addr == 8'h61, "R9", "push with commit dropped", rd_addr, 8'h61);
        wait_idle(n);
        check(we_cnt == 1, "R9", "single strobe", we_cnt, 1);
        check(we_addr[0] == 8'h60 && we_data[0] == 8'h11, "R9", "written byte", we_data[0], 8'h11);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog all-requirements actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule